// File: doc/BRIEF.md
# Manchester Response Frame Decoder

This block turns a stream of half-bit-period modulation flags into the data bytes of one answer from a contactless tag. The front end presents one flag per half bit period on `half_valid_i`/`mod_i`. While idle, the decoder waits for a modulated half. That half is taken as the first half of a bit period, and the block checks that a fixed three-period start-of-frame pattern follows.

Once the start of frame has been accepted, each bit period is classified by which of its two halves carry modulation. A modulated second half alone means a one. A modulated first half alone means a zero. Bits are collected least significant first and a byte is emitted after every eight. A period with both halves modulated closes the frame. Any bits still pending at that point, except the final closing bit, are right-aligned and emitted as a short last byte. A frame-done pulse reports the number of bytes emitted in the frame. A malformed frame produces an error pulse, and the decoder then ignores one further period before it starts looking for a new frame.

Top module: `mdec_resp_decoder`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `byte_valid_o`, `frame_done_o` and `error_o` are low.
- R2: While idle, unmodulated halves are ignored and produce no output. The first modulated half becomes the first half of a bit period, and halves then pair strictly in arrival order.
- R3: A start of frame is accepted only as the period sequence both-halves, second-half-only, second-half-only, with the pair written {first,second} as 11, 01, 01. Any other period in that sequence raises one `error_o` pulse.
- R4: After the start of frame, a second-half-only period (01) decodes as bit value 1 and a first-half-only period (10) decodes as bit value 0.
- R5: The first decoded bit of a byte becomes bit 0 of `byte_data_o`. After eight bits, `byte_valid_o` pulses with `byte_nbits_o` = 8.
- R6: A both-halves period (11) after the start of frame ends the frame. If n > 1 bits are pending, one more byte is emitted with `byte_nbits_o` = n-1, holding the first n-1 of those bits right-aligned with zeros above them. If n is 0 or 1, no extra byte is emitted.
- R7: A both-halves period immediately after the start of frame, when no bit has been decoded, raises `error_o` and not `frame_done_o`.
- R8: A period with no modulation (00) immediately after the start of frame ends the frame with zero bytes. A period with no modulation after at least one data bit raises `error_o`.
- R9: After an error, exactly one further period is discarded whatever its content, and the next modulated half starts a new search.
- R10: `frame_done_o` pulses once per good frame, in the same cycle as any final partial byte, and `frame_len_o` gives the number of bytes emitted in that frame, counting the partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| half_valid_i | input | 1 | One half bit period sample is present |
| mod_i | input | 1 | Modulation seen in that half |
| byte_valid_o | output | 1 | Byte strobe |
| byte_data_o | output | BYTE_W | Decoded byte, right-aligned |
| byte_nbits_o | output | $clog2(BYTE_W+1) | Number of valid bits in the byte |
| frame_done_o | output | 1 | Frame ended cleanly |
| frame_len_o | output | LEN_W | Bytes emitted in the finished frame |
| error_o | output | 1 | Malformed frame |

## Verification
A half-bit alignment slip shows at the ports as swapped bit values or as a spurious error, one edge after the period that completes. A wrong control state becomes visible at the next period, as an error pulse where a byte was due or as a frame that decodes when it should not. Errors in the shift register or in the bit counter show up in the byte values and in `byte_nbits_o`, but only when a byte or the end of the frame is reported.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  // {first_half, second_half}
  typedef enum logic [1:0] {
    PER_NONE   = 2'b00,
    PER_SECOND = 2'b01,
    PER_FIRST  = 2'b10,
    PER_BOTH   = 2'b11
  } period_e;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SOF_B,
    ST_SOF_C,
    ST_SOF_DONE,
    ST_DATA,
    ST_ERR_WAIT
  } state_e;
endpackage

// File: rtl/mdec_period.sv
module mdec_period
  import mdec_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    half_valid_i,
  input  logic    mod_i,
  input  logic    hunt_i,
  output logic    prd_valid_o,
  output period_e prd_o
);
  logic phase_q, first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= 1'b0;
      first_q     <= 1'b0;
      prd_valid_o <= 1'b0;
      prd_o       <= PER_NONE;
    end else begin
      prd_valid_o <= 1'b0;
      if (half_valid_i) begin
        if (!phase_q) begin
          // while hunting only a modulated half may open a period
          if (!(hunt_i && !mod_i)) begin
            phase_q <= 1'b1;
            first_q <= mod_i;
          end
        end else begin
          phase_q     <= 1'b0;
          prd_valid_o <= 1'b1;
          prd_o       <= period_e'({first_q, mod_i});
        end
      end
    end
  end

  a_r2_period_follows_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_valid_o |-> $past(half_valid_i));
endmodule

// File: rtl/mdec_assembler.sv
module mdec_assembler #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LEN_W  = 6,
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic              bit_i,
  input  logic              eof_i,
  output logic              any_data_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic [CNT_W-1:0]  byte_nbits_o,
  output logic              frame_done_o,
  output logic [LEN_W-1:0]  frame_len_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [BYTE_W-1:0] sr_q, sr_n, part, mask;
  logic [CNT_W-1:0]  nbit_q;
  logic [LEN_W-1:0]  len_q, len_inc;

  always_comb begin
    sr_n    = {bit_i, sr_q[BYTE_W-1:1]};
    // keep the n-1 oldest bits, dropping the closing bit
    mask    = {BYTE_W{1'b1}} >> (FULL - nbit_q + ONE);
    part    = (sr_q >> (FULL - nbit_q)) & mask;
    len_inc = (&len_q) ? len_q : len_q + LEN_W'(1);
  end

  assign any_data_o = (nbit_q != '0) || (len_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q         <= '0;
      nbit_q       <= '0;
      len_q        <= '0;
      byte_valid_o <= 1'b0;
      byte_data_o  <= '0;
      byte_nbits_o <= '0;
      frame_done_o <= 1'b0;
      frame_len_o  <= '0;
    end else begin
      byte_valid_o <= 1'b0;
      frame_done_o <= 1'b0;
      if (clear_i) begin
        sr_q   <= '0;
        nbit_q <= '0;
        len_q  <= '0;
      end else if (push_i) begin
        if (nbit_q == FULL - ONE) begin
          byte_valid_o <= 1'b1;
          byte_data_o  <= sr_n;
          byte_nbits_o <= FULL;
          len_q        <= len_inc;
          sr_q         <= '0;
          nbit_q       <= '0;
        end else begin
          sr_q   <= sr_n;
          nbit_q <= nbit_q + ONE;
        end
      end else if (eof_i) begin
        frame_done_o <= 1'b1;
        if (nbit_q > ONE) begin
          byte_valid_o <= 1'b1;
          byte_data_o  <= part;
          byte_nbits_o <= nbit_q - ONE;
          frame_len_o  <= len_inc;
        end else begin
          frame_len_o  <= len_q;
        end
      end
    end
  end

  a_r5_byte_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> (byte_nbits_o != '0) && (byte_nbits_o <= FULL)
                     && ((byte_data_o >> byte_nbits_o) == '0));

  a_r6_partial_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && frame_done_o) |-> (byte_nbits_o <= FULL - ONE - ONE));
endmodule

// File: rtl/mdec_ctrl.sv
module mdec_ctrl
  import mdec_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    prd_valid_i,
  input  period_e prd_i,
  input  logic    any_data_i,
  output logic    hunt_o,
  output logic    clear_o,
  output logic    push_o,
  output logic    bit_o,
  output logic    eof_o,
  output logic    error_o
);
  state_e state_q, state_d;
  logic   err_d;

  always_comb begin
    state_d = state_q;
    push_o  = 1'b0;
    bit_o   = 1'b0;
    eof_o   = 1'b0;
    err_d   = 1'b0;
    if (prd_valid_i) begin
      unique case (state_q)
        ST_HUNT:  if (prd_i == PER_BOTH)   state_d = ST_SOF_B;    else err_d = 1'b1;
        ST_SOF_B: if (prd_i == PER_SECOND) state_d = ST_SOF_C;    else err_d = 1'b1;
        ST_SOF_C: if (prd_i == PER_SECOND) state_d = ST_SOF_DONE; else err_d = 1'b1;
        ST_SOF_DONE, ST_DATA: begin
          unique case (prd_i)
            PER_SECOND: begin push_o = 1'b1; bit_o = 1'b1; state_d = ST_DATA; end
            PER_FIRST:  begin push_o = 1'b1; bit_o = 1'b0; state_d = ST_DATA; end
            PER_BOTH: begin
              if (any_data_i) begin eof_o = 1'b1; state_d = ST_HUNT; end
              else err_d = 1'b1;
            end
            default: begin
              if (state_q == ST_SOF_DONE) begin eof_o = 1'b1; state_d = ST_HUNT; end
              else err_d = 1'b1;
            end
          endcase
        end
        default: state_d = ST_HUNT;
      endcase
      if (err_d) state_d = ST_ERR_WAIT;
    end
  end

  assign hunt_o  = (state_d == ST_HUNT);
  assign clear_o = (state_q == ST_HUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      error_o <= 1'b0;
    end else begin
      state_q <= state_d;
      error_o <= err_d;
    end
  end

  a_r9_wait_one_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERR_WAIT && prd_valid_i) |=> (state_q == ST_HUNT));

  a_r3_sof_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT && prd_valid_i && prd_i != PER_BOTH) |=> error_o);
endmodule

// File: rtl/mdec_resp_decoder.sv
module mdec_resp_decoder
  import mdec_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LEN_W  = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         half_valid_i,
  input  logic                         mod_i,
  output logic                         byte_valid_o,
  output logic [BYTE_W-1:0]            byte_data_o,
  output logic [$clog2(BYTE_W+1)-1:0]  byte_nbits_o,
  output logic                         frame_done_o,
  output logic [LEN_W-1:0]             frame_len_o,
  output logic                         error_o
);
  logic    prd_valid, hunt, clear, push, bit_v, eof, any_data;
  period_e prd;

  mdec_period u_period (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .half_valid_i(half_valid_i),
    .mod_i       (mod_i),
    .hunt_i      (hunt),
    .prd_valid_o (prd_valid),
    .prd_o       (prd)
  );

  mdec_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prd_valid_i(prd_valid),
    .prd_i      (prd),
    .any_data_i (any_data),
    .hunt_o     (hunt),
    .clear_o    (clear),
    .push_o     (push),
    .bit_o      (bit_v),
    .eof_o      (eof),
    .error_o    (error_o)
  );

  mdec_assembler #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .push_i      (push),
    .bit_i       (bit_v),
    .eof_i       (eof),
    .any_data_o  (any_data),
    .byte_valid_o(byte_valid_o),
    .byte_data_o (byte_data_o),
    .byte_nbits_o(byte_nbits_o),
    .frame_done_o(frame_done_o),
    .frame_len_o (frame_len_o)
  );

  a_r7_done_xor_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_done_o && error_o));

  a_r8_no_byte_on_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !byte_valid_o);
endmodule

// File: tb/sim_mdec_resp_decoder.sv
`timescale 1ns/1ps
module sim_mdec_resp_decoder;
  localparam int K_BYTE = 0, K_DONE = 1, K_ERR = 2;

  typedef struct {
    int         kind;
    logic [7:0] d;
    logic [3:0] n;
    int         len;
    string      req;
  } exp_t;

  logic       clk = 1'b0, rst_n = 1'b0, hv = 1'b0, md = 1'b0;
  logic       byte_valid, frame_done, err;
  logic [7:0] byte_data;
  logic [3:0] byte_nbits;
  logic [5:0] frame_len;

  exp_t q[$];
  int   checks = 0, fails = 0, events = 0;
  bit   finished = 0;

  always #4 clk = ~clk;

  mdec_resp_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .half_valid_i(hv), .mod_i(md),
    .byte_valid_o(byte_valid), .byte_data_o(byte_data), .byte_nbits_o(byte_nbits),
    .frame_done_o(frame_done), .frame_len_o(frame_len), .error_o(err)
  );

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: %s", req, msg); end
  endtask

  task automatic pop_check(input int kind);
    exp_t e;
    if (q.size() == 0) begin
      check(0, "R2", $sformatf("unexpected event kind %0d, expected none", kind));
      return;
    end
    e = q.pop_front();
    if (kind != e.kind)
      check(0, e.req, $sformatf("event kind %0d, expected %0d", kind, e.kind));
    else if (kind == K_BYTE)
      check(byte_data == e.d && byte_nbits == e.n, e.req,
            $sformatf("byte %h/%0d bits, expected %h/%0d", byte_data, byte_nbits, e.d, e.n));
    else if (kind == K_DONE)
      check(frame_len == 6'(e.len), e.req,
            $sformatf("frame length %0d, expected %0d", frame_len, e.len));
    else
      check(1, e.req, "");
  endtask

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (byte_valid) begin events++; pop_check(K_BYTE); end
    if (frame_done) begin events++; pop_check(K_DONE); end
    if (err)        begin events++; pop_check(K_ERR);  end
  end

  task automatic push_exp(input int kind, input logic [7:0] d, input logic [3:0] n,
                          input int len, input string req);
    exp_t e;
    e.kind = kind; e.d = d; e.n = n; e.len = len; e.req = req;
    q.push_back(e);
  endtask

  task automatic half(input logic m);
    @(negedge clk); hv = 1'b1; md = m;
    @(negedge clk); hv = 1'b0; md = 1'b0;
  endtask

  task automatic period(input logic f, input logic s);
    half(f); half(s);
  endtask

  task automatic sof();
    period(1, 1); period(0, 1); period(0, 1);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      if (v[i]) period(0, 1); else period(1, 0);
    end
  endtask

  // good frame with n >= 1 bits, LSB first; expectations derived from R5, R6, R10
  task automatic frame(input logic [31:0] v, input int n, input string req);
    int full, r, len;
    logic [31:0] rest;
    full = n / 8; r = n % 8; len = full;
    for (int k = 0; k < full; k++) push_exp(K_BYTE, v[8*k +: 8], 4'd8, 0, req);
    if (r > 1) begin
      rest = (v >> (n - r)) & ((32'd1 << (r - 1)) - 32'd1);
      push_exp(K_BYTE, rest[7:0], 4'(r - 1), 0, "R6");
      len++;
    end
    push_exp(K_DONE, 8'h0, 4'h0, len, "R10");
    sof(); send_bits(v, n); period(1, 1);
  endtask

  initial begin
    int ev0;
    repeat (3) @(negedge clk);
    check(!byte_valid && !frame_done && !err, "R1", "outputs active in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(!byte_valid && !frame_done && !err, "R1", "outputs active after reset");

    // R2: idle unmodulated halves produce nothing and do not shift alignment
    ev0 = events;
    repeat (5) half(0);
    repeat (4) @(negedge clk);
    check(events == ev0, "R2", $sformatf("%0d events while idle, expected 0", events - ev0));

    // R4, R5: two full bytes
    frame(32'h3CA5, 16, "R5");
    frame(32'h00FF, 16, "R4");
    // R6: 8 + 5 bits -> full byte + 4-bit partial
    frame(32'h1A6C, 13, "R6");
    // R6: 8 + 1 bits -> no partial
    frame(32'h1E7, 9, "R6");
    // R6: single bit -> done with zero bytes
    frame(32'h1, 1, "R6");
    // R6: 3 bits -> 2-bit partial
    frame(32'h6, 3, "R6");

    // R8: no modulation right after SOF -> empty good frame
    push_exp(K_DONE, 8'h0, 4'h0, 0, "R8");
    sof(); period(0, 0);

    // R7: EOF directly after SOF -> error, then one discarded period
    push_exp(K_ERR, 8'h0, 4'h0, 0, "R7");
    sof(); period(1, 1); period(0, 0);

    // R3 + R9: bad second SOF period, discarded period that looks like SOF start
    push_exp(K_ERR, 8'h0, 4'h0, 0, "R3");
    period(1, 1); period(1, 0); period(1, 1);
    frame(32'h5A, 8, "R9");

    // R3: first period only first-half -> error, discarded period, good frame
    push_exp(K_ERR, 8'h0, 4'h0, 0, "R3");
    period(1, 0); period(0, 1);
    frame(32'hC3, 8, "R3");

    // R8: unmodulated period after data -> error
    push_exp(K_ERR, 8'h0, 4'h0, 0, "R8");
    sof(); send_bits(32'h5, 3); period(0, 0); period(0, 0);
    frame(32'h2B1, 10, "R9");

    repeat (20) @(negedge clk);
    check(q.size() == 0, "R10", $sformatf("%0d expected events missing, expected 0", q.size()));
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R1: watchdog expired, actual hung, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule